// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel characters into asynchronous serial frames. Software stages a character in a one-entry holding buffer. The buffer feeds a shift register, which sends a low start bit, then the data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Each bit is held on the line for a fixed number of baud ticks. The baud tick is a one-cycle pulse that comes from outside the block.

Two register-style write strobes set the configuration. The control strobe loads the enable, the top bit of the character-size code and the staged ninth data bit. The format strobe loads the two low size bits, the parity mode and the stop-bit count. A separate strobe writes a data byte. That write also captures the staged ninth bit. While the transmitter is active it owns the serial pin and raises an override flag. While it is inactive the pin carries a general-purpose port value. Clearing the enable only takes effect once the holding buffer and the shift register have both drained.

Top module: `usart_tx_core`

## Requirements
- R1: While `pin_override` is low, `pin_out` equals `port_value`. While the transmitter is active, `pin_override` is high and the line idles high between frames.
- R2: Enable takes effect one cycle after the control write. After the enable is cleared, the block stays active while a frame is shifting or a character is held. `pin_override` falls one cycle after both are empty.
- R3: The character size code is {`size_msb`, `size_lsbs`}. Codes 000, 001, 010 and 011 select 5, 6, 7 and 8 data bits, code 111 selects 9, and codes 100, 101 and 110 select 8.
- R4: A data write captures `ninth_bit` as data bit 8, using the value registered before that write. Later changes to `ninth_bit` do not alter a character that has already been written.
- R5: A frame consists of one low start bit, the data bits sent LSB first, an optional parity bit, and then stop bits that are high. `two_stop`=0 gives one stop bit and `two_stop`=1 gives two. Each bit lasts 16 `baud_tick` pulses. The start bit appears on the cycle after a character enters an idle shifter.
- R6: `par_sel` 00 sends no parity, and 01 is reserved and also sends no parity. 10 sends even parity and 11 sends odd parity. Parity is computed over the data bits of the frame.
- R7: After reset the block is disabled, the size code is 011 (8 bits), parity is off, one stop bit is selected, `buf_empty` is 1 and `tx_done` is 0.
- R8: `buf_empty` is high whenever the holding buffer can accept a character. A data write is ignored when the buffer is full or the block is inactive.
- R9: `tx_done` rises in the cycle after the last stop bit ends, provided the holding buffer is empty at that point. An accepted data write clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | One-cycle bit-time subdivision pulse |
| ctl_we | input | 1 | Control write strobe |
| en_bit | input | 1 | Transmitter enable (with ctl_we) |
| size_msb | input | 1 | Size code bit 2 (with ctl_we) |
| ninth_bit | input | 1 | Staged ninth data bit (with ctl_we) |
| fmt_we | input | 1 | Format write strobe |
| size_lsbs | input | 2 | Size code bits 1:0 (with fmt_we) |
| par_sel | input | 2 | Parity mode (with fmt_we) |
| two_stop | input | 1 | Stop-bit count select (with fmt_we) |
| data_we | input | 1 | Data write strobe |
| data_in | input | 8 | Low eight data bits |
| port_value | input | 1 | General-purpose value for the pin |
| pin_out | output | 1 | Serial pin |
| pin_override | output | 1 | High while the transmitter owns the pin |
| buf_empty | output | 1 | Holding buffer can accept a character |
| tx_done | output | 1 | Transmission complete |

## Verification
A single 8-bit character on the default format checks the basic bit ordering. A burst of strobes on consecutive cycles separates writes that are accepted from writes that are dropped because the buffer is full. Size and parity sweeps run 5-, 6- and 7-bit frames with even, odd and reserved parity and with two stop bits. These sweeps expose an off-by-one in the parity slot or in the frame length. A 9-bit pair, with the staged bit flipped between the two writes, shows whether the ninth bit is captured at write time. A disable issued while a frame is shifting and a second character is held distinguishes a deferred release from an immediate one.

// File: rtl/usart_tx_pkg.sv
package usart_tx_pkg;

   localparam int MAX_DATA = 9;
   localparam int MAX_STOP = 2;
   localparam int FRAME_W  = 1 + MAX_DATA + 1 + MAX_STOP;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_RSVD = 2'b01,
      PAR_EVEN = 2'b10,
      PAR_ODD  = 2'b11
   } par_mode_e;

   typedef struct packed {
      logic [2:0] size;
      par_mode_e  par;
      logic       stop2;
   } frame_cfg_t;

   function automatic logic [3:0] data_bits(input logic [2:0] code);
      case (code)
         3'b000:  data_bits = 4'd5;
         3'b001:  data_bits = 4'd6;
         3'b010:  data_bits = 4'd7;
         3'b111:  data_bits = 4'd9;
         default: data_bits = 4'd8;
      endcase
   endfunction

endpackage

// File: rtl/usart_tx_ctl.sv
module usart_tx_ctl
   import usart_tx_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctl_we,
   input  logic       en_bit,
   input  logic       size_msb,
   input  logic       ninth_bit,
   input  logic       fmt_we,
   input  logic [1:0] size_lsbs,
   input  logic [1:0] par_sel,
   input  logic       two_stop,
   input  logic       hold_full,
   input  logic       shift_busy,
   output frame_cfg_t cfg,
   output logic       staged_b9,
   output logic       active
);

   logic       en_q;
   logic       msb_q;
   logic [1:0] lsb_q;
   par_mode_e  par_q;
   logic       stop_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q      <= 1'b0;
         msb_q     <= 1'b0;
         staged_b9 <= 1'b0;
         lsb_q     <= 2'b11;
         par_q     <= PAR_NONE;
         stop_q    <= 1'b0;
         active    <= 1'b0;
      end else begin
         // Disable is deferred while anything remains to send
         active <= en_q | hold_full | shift_busy;
         if (ctl_we) begin
            en_q      <= en_bit;
            msb_q     <= size_msb;
            staged_b9 <= ninth_bit;
         end
         if (fmt_we) begin
            lsb_q  <= size_lsbs;
            par_q  <= par_mode_e'(par_sel);
            stop_q <= two_stop;
         end
      end
   end

   assign cfg = '{size: {msb_q, lsb_q}, par: par_q, stop2: stop_q};

endmodule

// File: rtl/usart_tx_hold.sv
module usart_tx_hold #(
   parameter int DATA_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              active,
   input  logic [DATA_W-1:0] din,
   input  logic              take,
   output logic              full,
   output logic              accept,
   output logic [DATA_W-1:0] dout
);

   assign accept = wr & active & ~full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full <= 1'b0;
         dout <= '0;
      end else begin
         if (take)
            full <= 1'b0;
         else if (accept)
            full <= 1'b1;
         if (accept)
            dout <= din;
      end
   end

endmodule

// File: rtl/usart_tx_shift.sv
module usart_tx_shift
   import usart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter bit PARITY_EN     = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                baud_tick,
   input  logic                hold_full,
   input  logic [MAX_DATA-1:0] hold_data,
   input  frame_cfg_t          cfg,
   output logic                take,
   output logic                busy,
   output logic                line,
   output logic                finish
);

   localparam int TW = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
   localparam int BW = $clog2(FRAME_W + 1);
   localparam logic [TW-1:0] TICK_LAST = TW'(TICKS_PER_BIT - 1);

   logic [FRAME_W-1:0] sreg;
   logic [FRAME_W-1:0] frame;
   logic [BW-1:0]      bits_left;
   logic [BW-1:0]      frame_len;
   logic [TW-1:0]      tick_cnt;
   logic [3:0]         nd;
   logic               par_bit;
   logic               par_on;
   logic               bit_end;

   assign nd = data_bits(cfg.size);

   generate
      if (PARITY_EN) begin : g_par
         logic x;
         always_comb begin
            x = 1'b0;
            for (int i = 0; i < MAX_DATA; i++)
               if (4'(i) < nd) x = x ^ hold_data[i];
         end
         assign par_on  = cfg.par[1];
         assign par_bit = (cfg.par == PAR_ODD) ? ~x : x;
      end else begin : g_nopar
         assign par_on  = 1'b0;
         assign par_bit = 1'b0;
      end
   endgenerate

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < MAX_DATA; i++)
         if (4'(i) < nd) frame[1 + i] = hold_data[i];
      if (par_on) frame[BW'(nd) + BW'(1)] = par_bit;
      frame_len = BW'(1) + BW'(nd) + BW'(par_on) + BW'(1) + BW'(cfg.stop2);
   end

   assign take    = hold_full & ~busy;
   assign bit_end = busy & baud_tick & (tick_cnt == TICK_LAST);
   assign finish  = bit_end & (bits_left == BW'(1));
   assign line    = busy ? sreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sreg      <= '1;
         bits_left <= '0;
         tick_cnt  <= '0;
         busy      <= 1'b0;
      end else if (take) begin
         sreg      <= frame;
         bits_left <= frame_len;
         tick_cnt  <= '0;
         busy      <= 1'b1;
      end else if (busy && baud_tick) begin
         if (bit_end) begin
            tick_cnt  <= '0;
            sreg      <= {1'b1, sreg[FRAME_W-1:1]};
            bits_left <= bits_left - BW'(1);
            if (finish) busy <= 1'b0;
         end else begin
            tick_cnt <= tick_cnt + TW'(1);
         end
      end
   end

endmodule

// File: rtl/usart_tx_core.sv
module usart_tx_core
   import usart_tx_pkg::*;
#(
   parameter int TICKS_PER_BIT = 16,
   parameter bit PARITY_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       ctl_we,
   input  logic       en_bit,
   input  logic       size_msb,
   input  logic       ninth_bit,
   input  logic       fmt_we,
   input  logic [1:0] size_lsbs,
   input  logic [1:0] par_sel,
   input  logic       two_stop,
   input  logic       data_we,
   input  logic [7:0] data_in,
   input  logic       port_value,
   output logic       pin_out,
   output logic       pin_override,
   output logic       buf_empty,
   output logic       tx_done
);

   generate
      if (TICKS_PER_BIT < 2) begin : g_bad_ticks
         $error("TICKS_PER_BIT must be at least 2");
      end
   endgenerate

   frame_cfg_t          cfg;
   logic                staged_b9;
   logic                active;
   logic                hold_full;
   logic                accept;
   logic                take;
   logic                shift_busy;
   logic                line;
   logic                finish;
   logic [MAX_DATA-1:0] hold_data;

   usart_tx_ctl u_ctl (
      .clk(clk), .rst_n(rst_n),
      .ctl_we(ctl_we), .en_bit(en_bit), .size_msb(size_msb), .ninth_bit(ninth_bit),
      .fmt_we(fmt_we), .size_lsbs(size_lsbs), .par_sel(par_sel), .two_stop(two_stop),
      .hold_full(hold_full), .shift_busy(shift_busy),
      .cfg(cfg), .staged_b9(staged_b9), .active(active)
   );

   usart_tx_hold #(.DATA_W(MAX_DATA)) u_hold (
      .clk(clk), .rst_n(rst_n),
      .wr(data_we), .active(active), .din({staged_b9, data_in}),
      .take(take), .full(hold_full), .accept(accept), .dout(hold_data)
   );

   usart_tx_shift #(.TICKS_PER_BIT(TICKS_PER_BIT), .PARITY_EN(PARITY_EN)) u_shift (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .hold_full(hold_full), .hold_data(hold_data), .cfg(cfg),
      .take(take), .busy(shift_busy), .line(line), .finish(finish)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_done <= 1'b0;
      else if (accept)
         tx_done <= 1'b0;
      else if (finish && !hold_full)
         tx_done <= 1'b1;
   end

   assign pin_override = active;
   assign pin_out      = active ? line : port_value;
   assign buf_empty    = ~hold_full;

endmodule

// File: rtl/usart_tx_chk.sv
module usart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic pin_out,
   input logic pin_override,
   input logic port_value,
   input logic buf_empty,
   input logic tx_done,
   input logic busy
);

   AST_PORT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_override |-> pin_out == port_value);                      // R1

   AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_override && !busy) |-> pin_out);                          // R1

   AST_BUSY_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> pin_override);                                        // R2

   AST_DRAIN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pin_override) |-> (buf_empty && !busy));                 // R2

   AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !pin_out);                                     // R5

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      tx_done |-> (buf_empty && !busy));                             // R9

endmodule

bind usart_tx_core usart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_override(pin_override),
   .port_value(port_value), .buf_empty(buf_empty), .tx_done(tx_done),
   .busy(shift_busy)
);

// File: tb/sim_usart_tx_core.sv
`timescale 1ns/1ps
module sim_usart_tx_core;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       baud_tick = 1'b0;
   logic       ctl_we = 1'b0, en_bit = 1'b0, size_msb = 1'b0, ninth_bit = 1'b0;
   logic       fmt_we = 1'b0, two_stop = 1'b0;
   logic [1:0] size_lsbs = 2'b00, par_sel = 2'b00;
   logic       data_we = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic       port_value = 1'b0;
   logic       pin_out, pin_override, buf_empty, tx_done;

   usart_tx_core u0 (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick),
      .ctl_we(ctl_we), .en_bit(en_bit), .size_msb(size_msb), .ninth_bit(ninth_bit),
      .fmt_we(fmt_we), .size_lsbs(size_lsbs), .par_sel(par_sel), .two_stop(two_stop),
      .data_we(data_we), .data_in(data_in), .port_value(port_value),
      .pin_out(pin_out), .pin_override(pin_override),
      .buf_empty(buf_empty), .tx_done(tx_done)
   );

   always #4 clk = ~clk;   // 125 MHz

   int    n_vec = 0;
   int    n_bad = 0;
   int    cyc = 0;
   string cur_req = "R7";
   bit    done_flag = 1'b0;

   // Reference model state
   bit       m_en = 0, m_msb = 0, m_b9 = 0, m_stop2 = 0, m_act = 0, m_full = 0, m_done = 0;
   bit [1:0] m_lsb = 2'b11, m_par = 2'b00;
   bit [8:0] m_hdata = 0;
   int       m_tick = 0;
   bit       m_q[$];

   function automatic int width_of(bit [2:0] code);
      if (code == 3'b111) return 9;
      if (code[2] == 1'b0) return 5 + int'(code[1:0]);
      return 8;
   endfunction

   always @(posedge clk) begin
      if (rst_n) begin
         bit accept, busy, load, finish, new_act;
         int nd;
         bit p;
         accept  = data_we && m_act && !m_full;
         busy    = m_q.size() > 0;
         load    = !busy && m_full;
         finish  = busy && baud_tick && m_tick == 15 && m_q.size() == 1;
         new_act = m_en || m_full || busy;
         if (busy && baud_tick) begin
            if (m_tick == 15) begin m_tick = 0; void'(m_q.pop_front()); end
            else m_tick++;
         end
         if (load) begin
            nd = width_of({m_msb, m_lsb});
            p = 0;
            m_q.push_back(1'b0);
            for (int i = 0; i < nd; i++) begin m_q.push_back(m_hdata[i]); p ^= m_hdata[i]; end
            if (m_par == 2'b10) m_q.push_back(p);
            if (m_par == 2'b11) m_q.push_back(!p);
            m_q.push_back(1'b1);
            if (m_stop2) m_q.push_back(1'b1);
            m_tick = 0;
         end
         if (accept) m_done = 0;
         else if (finish && !m_full) m_done = 1;
         if (load) m_full = 0;
         else if (accept) begin m_full = 1; m_hdata = {m_b9, data_in}; end
         m_act = new_act;
         if (ctl_we) begin m_en = en_bit; m_msb = size_msb; m_b9 = ninth_bit; end
         if (fmt_we) begin m_lsb = size_lsbs; m_par = par_sel; m_stop2 = two_stop; end
      end
   end

   task automatic check1(string what, logic act, logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s at cycle %0d: got %b expected %b", cur_req, what, cyc, act, exp);
      end
   endtask

   always @(posedge clk) begin
      #1;
      if (rst_n) begin
         bit exp_pin;
         exp_pin = m_act ? ((m_q.size() > 0) ? m_q[0] : 1'b1) : port_value;
         check1("pin_out", pin_out, exp_pin);                 // R5
         check1("pin_override", pin_override, m_act);         // R1 R2
         check1("buf_empty", buf_empty, !m_full);             // R8
         check1("tx_done", tx_done, m_done);                  // R9
      end
   end

   // Baud ticks on two cycles out of three
   always @(negedge clk) begin
      cyc++;
      baud_tick <= (cyc % 3) != 2;
   end

   task automatic finish_run();
      if (!done_flag) begin
         done_flag = 1'b1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      if (cyc > 150000) begin
         n_bad++;
         $display("FAIL watchdog expired at cycle %0d: got running expected finished", cyc);
         finish_run();
      end
   end

   task automatic ctl_write(bit en, bit msb, bit b9);
      @(negedge clk);
      ctl_we = 1; en_bit = en; size_msb = msb; ninth_bit = b9;
      @(negedge clk);
      ctl_we = 0;
   endtask

   task automatic fmt_write(bit [1:0] lsb, bit [1:0] par, bit st2);
      @(negedge clk);
      fmt_we = 1; size_lsbs = lsb; par_sel = par; two_stop = st2;
      @(negedge clk);
      fmt_we = 0;
   endtask

   task automatic data_write(bit [7:0] d);
      @(negedge clk);
      data_we = 1; data_in = d;
      @(negedge clk);
      data_we = 0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (m_q.size() == 0 && !m_full) break;
      end
      repeat (3) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R7: reset state at the ports
      cur_req = "R7";
      check1("reset buf_empty", buf_empty, 1'b1);
      check1("reset tx_done", tx_done, 1'b0);
      check1("reset override", pin_override, 1'b0);

      // R1: port value passes while disabled; R8: write while inactive ignored
      cur_req = "R1";
      repeat (4) begin @(negedge clk); port_value = ~port_value; end
      cur_req = "R8";
      data_write(8'h77);
      repeat (4) @(negedge clk);

      // R5: default 8-bit, no parity, one stop bit
      cur_req = "R5";
      ctl_write(1, 0, 0);
      data_write(8'hA5);
      wait_idle();

      // R8: burst of strobes on consecutive cycles
      cur_req = "R8";
      @(negedge clk);
      data_we = 1; data_in = 8'h3C; @(negedge clk);
      data_in = 8'hC3; @(negedge clk);
      data_in = 8'h5A; @(negedge clk);
      data_in = 8'h99; @(negedge clk);
      data_we = 0;
      wait_idle();

      // R3 R6: size and parity sweep
      cur_req = "R6";
      fmt_write(2'b00, 2'b10, 1'b1);   // 5 bits, even, two stop
      data_write(8'h13);
      wait_idle();
      fmt_write(2'b01, 2'b11, 1'b0);   // 6 bits, odd
      data_write(8'h2E);
      wait_idle();
      cur_req = "R3";
      fmt_write(2'b10, 2'b01, 1'b0);   // 7 bits, reserved parity
      data_write(8'hFF);
      wait_idle();

      // R4: 9-bit frames with ninth bit flipped between writes
      cur_req = "R4";
      ctl_write(1, 1, 1);
      fmt_write(2'b11, 2'b10, 1'b0);
      data_write(8'h55);
      ctl_write(1, 1, 0);
      data_write(8'hAA);
      ctl_write(1, 1, 1);
      wait_idle();

      // R3: reserved size code 100 acts as 8 bits
      cur_req = "R3";
      ctl_write(1, 1, 0);
      fmt_write(2'b00, 2'b00, 1'b0);
      data_write(8'h81);
      wait_idle();

      // R2: disable while a frame shifts and another is held
      cur_req = "R2";
      ctl_write(1, 0, 0);
      fmt_write(2'b11, 2'b00, 1'b0);
      data_write(8'h0F);
      @(negedge clk);
      data_write(8'hF0);
      ctl_write(0, 0, 0);
      wait_idle();
      cur_req = "R8";
      data_write(8'h44);
      repeat (3) begin @(negedge clk); port_value = ~port_value; end
      repeat (4) @(negedge clk);

      // R9: done clears on write, re-sets after drain
      cur_req = "R9";
      ctl_write(1, 0, 0);
      data_write(8'h6B);
      wait_idle();
      ctl_write(0, 0, 0);
      repeat (4) @(negedge clk);

      finish_run();
   end

endmodule